// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This block merges the five interrupt causes of a 16550-style serial port into one prioritised identification code and one interrupt request line. A host reaches two registers through a small register port: an enable register that selects which causes may interrupt, and a read-only identification register that names the most urgent cause still pending.

The rest of the UART supplies status as plain inputs. Receiver line errors and modem line changes arrive as one-cycle strobes, and the block holds them until the matching status register is read. Received-data-available and character-timeout arrive as levels and are not stored. The transmit-empty condition is a level whose rising edge arms an interrupt. That interrupt is dismissed when the host acknowledges it. A FIFO-enabled flag is reflected in the top bits of the identification byte. A gate bit from the modem control register decides whether a pending interrupt reaches the request pin.

Top module: `uart_irq_ident`

## Requirements
- R1: The enable register sits at offset 1. It stores written bits 3:0 (bit0 received data and character timeout, bit1 transmit holding empty, bit2 receiver line status, bit3 modem status) and reads them back with bits 7:4 as zero. It resets to 0x00.
- R2: The identification register sits at offset 2. Its bit0 reads 1 when no enabled cause is pending and 0 when one is, so after reset with FIFOs off it reads 0x01.
- R3: Identification bits 3:0 are 0x6 for line status, 0x4 for received data, 0xC for character timeout, 0x2 for transmit holding empty and 0x0 for modem status.
- R4: When several enabled causes are pending, the code shown follows this order, highest first: line status, received data, character timeout, transmit holding empty, modem status.
- R5: Identification bits 7:6 read 11 while fifo_en_i is high and 00 otherwise. Bits 5:4 always read 0.
- R6: irq_o is high exactly when an enabled cause is pending and irq_gate_i is high.
- R7: A cause whose enable bit is 0 never clears identification bit0 and never raises irq_o, whatever its condition.
- R8: A line_err_i strobe sets a held line-status cause. A read at offset 5 clears it. If a strobe and the read fall in the same cycle, the cause stays set.
- R9: A modem_delta_i strobe sets a held modem cause. A read at offset 6 clears it, and a strobe in the same cycle wins.
- R10: The transmit-empty cause is set when thr_empty_i rises, or when enable bit1 is written from 0 to 1 while thr_empty_i is high. It is cleared by a write at offset 0, by a read at offset 2 while code 0x2 is shown, or by thr_empty_i going low. A set in the same cycle wins.
- R11: rx_avail_i and rx_timeout_i are not stored. Their effect on the code and on irq_o appears in the same cycle as the level, and it disappears in the same cycle as the level.
- R12: A write at offset 2 changes neither the enable register nor the identification value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Host write strobe |
| rd_en_i | input | 1 | Host read strobe (drives read side effects) |
| addr_i | input | 3 | Register offset |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Read data for addr_i (enable or identification register, else zero) |
| line_err_i | input | 1 | Receiver line error strobe |
| rx_avail_i | input | 1 | Received data available level |
| rx_timeout_i | input | 1 | Character timeout level |
| thr_empty_i | input | 1 | Transmit holding register empty level |
| modem_delta_i | input | 1 | Modem status change strobe |
| fifo_en_i | input | 1 | FIFOs enabled flag |
| irq_gate_i | input | 1 | Modem control IRQ enable bit |
| irq_o | output | 1 | Interrupt request |

## Verification
Level inputs, the FIFO flag, the gate bit and the addressed read data reach rdata_o and irq_o with no clock edge in between. The bench therefore samples those one time step after it changes the inputs, within the same cycle. Strobes, register writes and read side effects act at the next rising edge. Their effect is checked one step after that edge, while the inputs of that cycle are still held. A bench model of the enable register and the three held causes advances at the same edge from the same held inputs, and it supplies the expected byte for every random cycle.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam int unsigned OFS_THR = 0;
  localparam int unsigned OFS_IER = 1;
  localparam int unsigned OFS_IIR = 2;
  localparam int unsigned OFS_LSR = 5;
  localparam int unsigned OFS_MSR = 6;

  localparam int unsigned IE_RX    = 0;
  localparam int unsigned IE_TX    = 1;
  localparam int unsigned IE_LINE  = 2;
  localparam int unsigned IE_MODEM = 3;

  localparam logic [3:0] IID_LINE    = 4'h6;
  localparam logic [3:0] IID_RXDATA  = 4'h4;
  localparam logic [3:0] IID_TIMEOUT = 4'hC;
  localparam logic [3:0] IID_TXEMPTY = 4'h2;
  localparam logic [3:0] IID_MODEM   = 4'h0;
  localparam logic [3:0] IID_NONE    = 4'h1;

  // index order is priority order, 0 highest
  typedef enum logic [2:0] {
    SRC_LINE    = 3'd0,
    SRC_RXDATA  = 3'd1,
    SRC_TIMEOUT = 3'd2,
    SRC_TXEMPTY = 3'd3,
    SRC_MODEM   = 3'd4
  } irq_src_e;

  localparam int unsigned NUM_SRC = 5;

  function automatic logic [3:0] src_code(input int idx);
    case (idx)
      0:       return IID_LINE;
      1:       return IID_RXDATA;
      2:       return IID_TIMEOUT;
      3:       return IID_TXEMPTY;
      4:       return IID_MODEM;
      default: return IID_NONE;
    endcase
  endfunction

endpackage

// File: rtl/irq_flag.sv
module irq_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

  // shared by the line, modem and transmit-empty causes (R8, R9, R10)
  assert_flag_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o);
  assert_flag_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !flag_o);

endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned IER_W  = 4,
  parameter int unsigned OFS    = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [IER_W-1:0]  wdata_i,
  output logic [IER_W-1:0]  ier_o,
  output logic [IER_W-1:0]  rise_o
);

  localparam logic [ADDR_W-1:0] A_HIT = ADDR_W'(OFS);

  logic hit;
  assign hit    = wr_en_i && (addr_i == A_HIT);
  assign rise_o = hit ? (wdata_i & ~ier_o) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  ier_o <= '0;
    else if (hit) ier_o <= wdata_i;
  end

  assert_ier_write_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_HIT) |=> (ier_o == $past(wdata_i)));
  assert_ier_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == A_HIT) |=> $stable(ier_o));

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import uart_irq_pkg::*;
#(
  parameter int unsigned N = NUM_SRC
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] grant_o,
  output logic [3:0]   code_o,
  output logic         pending_o
);

  // walk from lowest to highest priority so the highest request overrides
  always_comb begin
    grant_o = '0;
    code_o  = IID_NONE;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        grant_o    = '0;
        grant_o[i] = 1'b1;
        code_o     = src_code(i);
      end
    end
  end

  assign pending_o = |grant_o;

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned IER_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              line_err_i,
  input  logic              rx_avail_i,
  input  logic              rx_timeout_i,
  input  logic              thr_empty_i,
  input  logic              modem_delta_i,
  input  logic              fifo_en_i,
  input  logic              irq_gate_i,
  output logic              irq_o
);

  localparam logic [ADDR_W-1:0] A_THR = ADDR_W'(OFS_THR);
  localparam logic [ADDR_W-1:0] A_IER = ADDR_W'(OFS_IER);
  localparam logic [ADDR_W-1:0] A_IIR = ADDR_W'(OFS_IIR);
  localparam logic [ADDR_W-1:0] A_LSR = ADDR_W'(OFS_LSR);
  localparam logic [ADDR_W-1:0] A_MSR = ADDR_W'(OFS_MSR);
  localparam int unsigned NUM_HELD = 2;

  logic [IER_W-1:0]   ier_q, ier_rise;
  logic [NUM_SRC-1:0] req, grant;
  logic [3:0]         code;
  logic               pending;
  logic [DATA_W-1:0]  iir_byte;
  logic               thr_q, thre_flag, thre_set, thre_clr;
  logic [NUM_HELD-1:0] held_set, held_clr, held_flag;
  logic               unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:IER_W];

  irq_enable_reg #(.ADDR_W(ADDR_W), .IER_W(IER_W), .OFS(OFS_IER)) u_ier (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i[IER_W-1:0]),
    .ier_o   (ier_q),
    .rise_o  (ier_rise)
  );

  // held causes: [0] line status, [1] modem status
  assign held_set = {modem_delta_i, line_err_i};
  assign held_clr = {rd_en_i && addr_i == A_MSR, rd_en_i && addr_i == A_LSR};

  for (genvar g = 0; g < NUM_HELD; g++) begin : g_held
    irq_flag u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (held_set[g]),
      .clr_i  (held_clr[g]),
      .flag_o (held_flag[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) thr_q <= 1'b0;
    else         thr_q <= thr_empty_i;
  end

  assign thre_set = thr_empty_i && (!thr_q || ier_rise[IE_TX]);
  assign thre_clr = (wr_en_i && addr_i == A_THR)
                  || (rd_en_i && addr_i == A_IIR && grant[SRC_TXEMPTY])
                  || !thr_empty_i;

  irq_flag u_thre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (thre_set),
    .clr_i  (thre_clr),
    .flag_o (thre_flag)
  );

  always_comb begin
    req              = '0;
    req[SRC_LINE]    = ier_q[IE_LINE]  && held_flag[0];
    req[SRC_RXDATA]  = ier_q[IE_RX]    && rx_avail_i;
    req[SRC_TIMEOUT] = ier_q[IE_RX]    && rx_timeout_i;
    req[SRC_TXEMPTY] = ier_q[IE_TX]    && thre_flag;
    req[SRC_MODEM]   = ier_q[IE_MODEM] && held_flag[1];
  end

  irq_prio_enc #(.N(NUM_SRC)) u_enc (
    .req_i     (req),
    .grant_o   (grant),
    .code_o    (code),
    .pending_o (pending)
  );

  assign iir_byte = {{2{fifo_en_i}}, {(DATA_W-6){1'b0}}, code};
  assign irq_o    = pending && irq_gate_i;

  always_comb begin
    case (addr_i)
      A_IER:   rdata_o = {{(DATA_W-IER_W){1'b0}}, ier_q};
      A_IIR:   rdata_o = iir_byte;
      default: rdata_o = '0;
    endcase
  end

  assert_grant_onehot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant));
  assert_irq_pending_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (irq_gate_i && !iir_byte[0]));
  assert_masked_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ier_q == '0) |-> (!irq_o && iir_byte[0]));
  assert_thre_ack_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == A_IIR && code == IID_TXEMPTY && !thre_set) |=> !thre_flag);

endmodule

// File: tb/uart_irq_ident_tb_top.sv
module uart_irq_ident_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int N_RANDOM   = 3000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [2:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       line_err_i = 1'b0, rx_avail_i = 1'b0, rx_timeout_i = 1'b0;
  logic       thr_empty_i = 1'b0, modem_delta_i = 1'b0;
  logic       fifo_en_i = 1'b0, irq_gate_i = 1'b0;
  logic       irq_o;

  int n_chk = 0;
  int n_err = 0;

  logic [3:0] m_ier;
  logic       m_ls, m_ms, m_thre, m_thr_prev;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  uart_irq_ident dut_i (
    .clk_i, .rst_ni, .wr_en_i, .rd_en_i, .addr_i, .wdata_i, .rdata_o,
    .line_err_i, .rx_avail_i, .rx_timeout_i, .thr_empty_i, .modem_delta_i,
    .fifo_en_i, .irq_gate_i, .irq_o
  );

  function automatic logic [3:0] exp_code();
    if (m_ier[2] && m_ls)              return 4'h6;
    if (m_ier[0] && rx_avail_i)        return 4'h4;
    if (m_ier[0] && rx_timeout_i)      return 4'hC;
    if (m_ier[1] && m_thre)            return 4'h2;
    if (m_ier[3] && m_ms)              return 4'h0;
    return 4'h1;
  endfunction

  function automatic logic [7:0] exp_rdata(input logic [2:0] a);
    if (a == 3'd1) return {4'h0, m_ier};
    if (a == 3'd2) return {{2{fifo_en_i}}, 2'b00, exp_code()};
    return 8'h00;
  endfunction

  function automatic logic exp_irq();
    return !exp_code()[0] && irq_gate_i;
  endfunction

  task automatic model_reset();
    m_ier = '0; m_ls = 0; m_ms = 0; m_thre = 0; m_thr_prev = 0;
  endtask

  // advance model with the inputs held during the cycle that just ended
  task automatic model_update();
    logic ier_wr, thre_set, thre_clr;
    logic [3:0] c;
    c        = exp_code();
    ier_wr   = wr_en_i && addr_i == 3'd1;
    thre_set = thr_empty_i && (!m_thr_prev || (ier_wr && wdata_i[1] && !m_ier[1]));
    thre_clr = (wr_en_i && addr_i == 3'd0) || (rd_en_i && addr_i == 3'd2 && c == 4'h2)
               || !thr_empty_i;
    m_thre   = thre_set || (m_thre && !thre_clr);
    m_ls     = line_err_i || (m_ls && !(rd_en_i && addr_i == 3'd5));
    m_ms     = modem_delta_i || (m_ms && !(rd_en_i && addr_i == 3'd6));
    m_thr_prev = thr_empty_i;
    if (ier_wr) m_ier = wdata_i[3:0];
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
    model_update();
    wr_en_i = 0; rd_en_i = 0; line_err_i = 0; modem_delta_i = 0;
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic peek(input string req, input logic [2:0] a, input logic [7:0] exp);
    addr_i = a;
    #1;
    check(req, rdata_o, exp);
  endtask

  task automatic do_write(input logic [2:0] a, input logic [7:0] d);
    wr_en_i = 1; addr_i = a; wdata_i = d;
    tick();
  endtask

  task automatic do_read(input logic [2:0] a);
    rd_en_i = 1; addr_i = a;
    tick();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_err++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    #(CLK_PERIOD * 3);
    rst_ni = 1'b1;
    tick();

    // reset state
    peek("R2 reset iir", 3'd2, 8'h01);
    peek("R1 reset ier", 3'd1, 8'h00);
    check("R6 reset irq", {7'd0, irq_o}, 8'h00);

    fifo_en_i = 1;
    peek("R5 fifo bits", 3'd2, 8'hC1);
    fifo_en_i = 0;

    // all causes active while masked
    irq_gate_i = 1; rx_avail_i = 1; line_err_i = 1; modem_delta_i = 1; thr_empty_i = 1;
    tick();
    peek("R7 masked iir", 3'd2, 8'h01);
    check("R7 masked irq", {7'd0, irq_o}, 8'h00);

    do_write(3'd1, 8'hFF);
    peek("R1 ier upper zero", 3'd1, 8'h0F);
    peek("R4 line first", 3'd2, 8'h06);
    check("R6 irq gated on", {7'd0, irq_o}, 8'h01);
    irq_gate_i = 0; #1;
    check("R6 irq gated off", {7'd0, irq_o}, 8'h00);
    irq_gate_i = 1;

    do_read(3'd5);
    peek("R8 lsr read clears", 3'd2, 8'h04);
    rx_avail_i = 0; rx_timeout_i = 1;
    peek("R11 timeout level", 3'd2, 8'h0C);
    rx_timeout_i = 0;
    peek("R3 thre code", 3'd2, 8'h02);

    do_read(3'd2);
    peek("R10 iir read ack", 3'd2, 8'h00);
    do_read(3'd6);
    peek("R9 msr read clears", 3'd2, 8'h01);

    line_err_i = 1; rd_en_i = 1; addr_i = 3'd5;
    tick();
    peek("R8 set wins", 3'd2, 8'h06);
    do_read(3'd5);

    thr_empty_i = 0; tick();
    thr_empty_i = 1; tick();
    peek("R10 rise sets", 3'd2, 8'h02);
    do_write(3'd0, 8'h55);
    peek("R10 thr write clears", 3'd2, 8'h01);

    do_write(3'd1, 8'h0D);
    do_write(3'd1, 8'h0F);
    peek("R10 enable while empty", 3'd2, 8'h02);

    do_write(3'd2, 8'h00);
    peek("R12 ier kept", 3'd1, 8'h0F);
    peek("R12 iir kept", 3'd2, 8'h02);

    // random phase against the bench model
    for (int i = 0; i < N_RANDOM; i++) begin
      int op;
      op = int'($urandom % 6);
      wr_en_i = (op == 0);
      rd_en_i = (op == 1 || op == 2);
      addr_i  = 3'($urandom % 8);
      wdata_i = 8'($urandom);
      line_err_i    = ($urandom % 8) == 0;
      modem_delta_i = ($urandom % 8) == 0;
      rx_avail_i    = ($urandom % 4) == 0;
      rx_timeout_i  = ($urandom % 8) == 0;
      if (($urandom % 4) == 0) thr_empty_i = !thr_empty_i;
      fifo_en_i  = 1'($urandom);
      irq_gate_i = ($urandom % 8) != 0;
      #1;
      check("R6 random irq", {7'd0, irq_o}, {7'd0, exp_irq()});
      check(addr_i == 3'd1 ? "R1 random ier" : "R4 random iir", rdata_o, exp_rdata(addr_i));
      tick();
    end

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule